// File: doc/BRIEF.md
# Register-Controlled Serial Flash Master with Byte Queues

This block is a serial peripheral interface master that a processor drives through a small 32-bit register window. Software stages a complete flash command (opcode, address bytes, payload or dummy bytes) in a transmit queue. It then lowers the chip select through a dedicated register and clears a transfer-hold bit. The block emits the whole queue as one uninterrupted burst and stores each byte returned by the slave in a receive queue, which software drains through a read-only data register.

Transfers use single-line mode 0. The serial clock idles low. The slave samples on the rising edge and both sides change data after the falling edge. The serial clock runs at the system clock divided by an even parameter. A status register reports the fill state of both queues and a sticky flag that marks a dropped receive byte.

Top module: `spi_reg_master`

## Requirements
- R1: After reset the hold bit reads 1 at control address 0x60 (bit 0). Status at 0x64 reads 0x05, where bit 0 is transmit empty, bit 1 transmit full, bit 2 receive empty, bit 3 receive full and bit 4 overrun. Chip select is high and the serial clock is low.
- R2: A register write takes effect only in a cycle where both the write-address valid and write-data valid inputs are high. Either valid alone changes nothing.
- R3: Writing 0x00 to address 0x70 drives the active-low chip select low. Writing 0x01 drives it high.
- R4: While the hold bit (control bit 0) is 1, no serial clock edge occurs and queued transmit bytes stay queued.
- R5: With the hold bit at 0 and chip select low, every queued transmit byte is sent MSB first on the data-out line. The line stays stable while the serial clock is high.
- R6: Each transmitted byte pushes exactly one received byte, sampled MSB first on the rising serial clock edges. Reading address 0x6C returns the received bytes in arrival order.
- R7: The serial clock idles low. Each bit lasts DIV system cycles, and the clock is high for DIV/2 of them.
- R8: Writing 1 to control bit 1 empties the transmit queue. Writing 1 to control bit 2 empties the receive queue and clears the overrun flag. Neither action affects the other queue.
- R9: Once DEPTH bytes are queued, transmit full (status bit 1) is set and any further write to 0x68 is discarded.
- R10: When a byte completes while the receive queue is full, that byte is discarded, the overrun flag is set, and the queued bytes are kept unchanged.
- R11: While chip select is high, no transfer starts, even with the hold bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_addr_vld | input | 1 | Write address valid |
| bus_wr_data_vld | input | 1 | Write data valid |
| bus_wr_addr | input | 8 | Write byte address |
| bus_wr_data | input | 32 | Write data word |
| bus_rd_req | input | 1 | Read request |
| bus_rd_addr | input | 8 | Read byte address |
| bus_rd_data | output | 32 | Read data, valid one cycle after the request |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The shift path is driven with 0x9C, 0x01 and 0x80, which separate MSB-first from LSB-first order and catch a lost first or last bit. The modelled slave returns a different byte for every transfer, so receive ordering and byte loss show up directly. Bursts are released either by clearing the hold bit or by lowering chip select, which tells the two gates apart. A full transmit queue and an overfilled receive queue exercise the discard paths and the overrun flag, and separate queue resets show that each reset leaves the other queue alone.

// File: rtl/spi_reg_pkg.sv
// Shared register map, bit positions and engine state type for the
// register-controlled serial master. Assumes byte addressing of 32-bit words.
package spi_reg_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] ADDR_CTRL = 8'h60;
    localparam logic [7:0] ADDR_STAT = 8'h64;
    localparam logic [7:0] ADDR_TXD  = 8'h68;
    localparam logic [7:0] ADDR_RXD  = 8'h6C;
    localparam logic [7:0] ADDR_SSEL = 8'h70;

    localparam int CTRL_HOLD   = 0;
    localparam int CTRL_TX_CLR = 1;
    localparam int CTRL_RX_CLR = 2;

    typedef struct packed {
        logic overrun;
        logic rx_full;
        logic rx_empty;
        logic tx_full;
        logic tx_empty;
    } status_t;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_t;
endpackage

// File: rtl/spi_fifo.sv
// Synchronous single-clock byte queue with a show-ahead head word.
// Assumes DEPTH is a power of two; pushes while full and pops while
// empty are ignored; clr has priority over push and pop.
module spi_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH):0] level
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW:0]      count;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];
    assign level   = count;

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance the pointers and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_sclk_div.sv
// Half-period tick generator for the serial clock. While run is high it
// pulses tick once every DIV/2 system cycles; it restarts when run drops.
// Assumes DIV is even and at least 2.
module spi_sclk_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    // Count system cycles inside each half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
// Mode-0 byte shifter. On go it takes one byte, drives it MSB first,
// samples the input line on each rising serial edge, and pulses rx_done
// with the assembled byte one cycle after the eighth falling edge.
// Assumes tick comes from a divider that runs while busy is high.
module spi_shift_engine
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              tx_pop,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_done
);
    localparam int BCW = $clog2(BYTE_W);

    eng_state_t        state;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic [BCW-1:0]    bit_idx;

    assign busy    = (state == ENG_SHIFT);
    assign tx_pop  = (state == ENG_IDLE) && go;
    assign mosi    = tx_sh[BYTE_W-1];
    assign rx_byte = rx_sh;

    // Sequence the eight bit periods of one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ENG_IDLE;
            sclk    <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_idx <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (go) begin
                        state   <= ENG_SHIFT;
                        tx_sh   <= tx_byte;
                        bit_idx <= '0;
                    end
                end
                default: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk  <= 1'b1;
                            rx_sh <= {rx_sh[BYTE_W-2:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (bit_idx == BCW'(BYTE_W - 1)) begin
                                state   <= ENG_IDLE;
                                rx_done <= 1'b1;
                                tx_sh   <= '0;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_reg_master.sv
// Top level: register decode, transmit and receive queues, divider and
// shift engine. A write needs both valids in one cycle; reads return data
// one cycle after the request, and a receive-data read pops the queue.
// Assumes DEPTH is 16 or 256 and DIV is even.
module spi_reg_master
    import spi_reg_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr_addr_vld,
    input  logic        bus_wr_data_vld,
    input  logic [7:0]  bus_wr_addr,
    input  logic [31:0] bus_wr_data,
    input  logic        bus_rd_req,
    input  logic [7:0]  bus_rd_addr,
    output logic [31:0] bus_rd_data,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int LW = $clog2(DEPTH) + 1;

    logic              wr_stb;
    logic              inhibit_q;
    logic              cs_n_q;
    logic              overrun_q;
    logic              tx_clr, rx_clr, tx_push, rx_pop;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
    logic [LW-1:0]     tx_level, rx_level;
    logic              eng_go, eng_pop, eng_busy, eng_done, div_tick;
    status_t           stat;

    assign wr_stb  = bus_wr_addr_vld && bus_wr_data_vld;
    assign tx_clr  = wr_stb && (bus_wr_addr == ADDR_CTRL) && bus_wr_data[CTRL_TX_CLR];
    assign rx_clr  = wr_stb && (bus_wr_addr == ADDR_CTRL) && bus_wr_data[CTRL_RX_CLR];
    assign tx_push = wr_stb && (bus_wr_addr == ADDR_TXD);
    assign rx_pop  = bus_rd_req && (bus_rd_addr == ADDR_RXD);
    assign eng_go  = !inhibit_q && !cs_n_q && !tx_empty;
    assign spi_cs_n = cs_n_q;

    assign stat = '{overrun: overrun_q, rx_full: rx_full, rx_empty: rx_empty,
                    tx_full: tx_full, tx_empty: tx_empty};

    // Hold bit and chip select registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inhibit_q <= 1'b1;
            cs_n_q    <= 1'b1;
        end else if (wr_stb) begin
            if (bus_wr_addr == ADDR_CTRL) inhibit_q <= bus_wr_data[CTRL_HOLD];
            if (bus_wr_addr == ADDR_SSEL) cs_n_q    <= bus_wr_data[0];
        end
    end

    // Sticky flag for a byte lost to a full receive queue.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr) begin
            overrun_q <= 1'b0;
        end else if (eng_done && rx_full) begin
            overrun_q <= 1'b1;
        end
    end

    // Registered read multiplexer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rd_data <= '0;
        end else if (bus_rd_req) begin
            case (bus_rd_addr)
                ADDR_CTRL: bus_rd_data <= {31'd0, inhibit_q};
                ADDR_STAT: bus_rd_data <= {27'd0, stat};
                ADDR_RXD:  bus_rd_data <= {24'd0, rx_head};
                ADDR_SSEL: bus_rd_data <= {31'd0, cs_n_q};
                default:   bus_rd_data <= '0;
            endcase
        end
    end

    spi_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .wdata(bus_wr_data[BYTE_W-1:0]),
        .pop(eng_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    spi_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(eng_done), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    spi_sclk_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .tick(div_tick)
    );

    spi_shift_engine u_engine (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .tx_byte(tx_head),
        .tick(div_tick), .miso(spi_miso), .tx_pop(eng_pop),
        .busy(eng_busy), .sclk(spi_sclk), .mosi(spi_mosi),
        .rx_byte(rx_byte), .rx_done(eng_done)
    );
endmodule

// File: rtl/spi_reg_master_chk.sv
// Property checker for spi_reg_master, attached with bind below.
module spi_reg_master_chk #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sclk,
    input logic                   mosi,
    input logic                   cs_n,
    input logic                   busy,
    input logic                   inhibit,
    input logic                   tx_clr,
    input logic                   tx_empty,
    input logic [$clog2(DEPTH):0] tx_level,
    input logic                   rx_full,
    input logic                   overrun
);
    a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    a_r4_start_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!inhibit));

    a_r11_start_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!cs_n));

    a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r8_tx_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_clr) |-> tx_empty);

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= ($clog2(DEPTH)+1)'(DEPTH));

    a_r10_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_full));
endmodule

bind spi_reg_master spi_reg_master_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .busy(eng_busy), .inhibit(inhibit_q),
    .tx_clr(tx_clr), .tx_empty(tx_empty), .tx_level(tx_level),
    .rx_full(rx_full), .overrun(overrun_q)
);

// File: tb/test_spi_reg_master.sv
// Directed bench: one task per scenario, each checking its own results.
module test_spi_reg_master;
    localparam int DEPTH = 16;
    localparam int DIV   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awv = 1'b0, wv = 1'b0, rd_req = 1'b0;
    logic [7:0]  wa = '0, ra = '0;
    logic [31:0] wd = '0;
    logic [31:0] rd_data;
    logic        sclk, cs_n, mosi, miso;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_reg_master #(.DEPTH(DEPTH), .DIV(DIV)) i_spi_reg_master (
        .clk(clk), .rst_n(rst_n), .bus_wr_addr_vld(awv), .bus_wr_data_vld(wv),
        .bus_wr_addr(wa), .bus_wr_data(wd), .bus_rd_req(rd_req),
        .bus_rd_addr(ra), .bus_rd_data(rd_data), .spi_sclk(sclk),
        .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
    );

    // Slave model and serial monitor.
    int   cyc = 0, nsent = 0, bit_i = 0, last_rise = 0, bit_gap = 0, hi_len = 0;
    logic prev_sclk = 1'b0;
    logic [7:0] sh = '0;
    logic [7:0] sent [64];

    function automatic logic [7:0] reply_of(int k);
        return 8'h3C ^ 8'(k * 29);
    endfunction

    assign miso = reply_of(nsent)[7 - bit_i];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!prev_sclk && sclk) begin
            sh = {sh[6:0], mosi};
            if (bit_i == 1) bit_gap = cyc - last_rise;
            last_rise = cyc;
            if (bit_i == 7) begin
                sent[nsent % 64] = sh;
                nsent = nsent + 1;
                bit_i = 0;
            end else begin
                bit_i = bit_i + 1;
            end
        end
        if (prev_sclk && !sclk) hi_len = cyc - last_rise;
        prev_sclk = sclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); awv = 1; wv = 1; wa = a; wd = d;
        @(negedge clk); awv = 0; wv = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_req = 1; ra = a;
        @(negedge clk); rd_req = 0; d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_sent(input int target);
        for (int i = 0; i < 5000 && nsent < target; i++) @(negedge clk);
        idle(2 * DIV);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h64, d); check(d == 32'h5, "R1 status", d, 5);
        rd(8'h60, d); check(d == 32'h1, "R1 hold", d, 1);
        check(cs_n == 1'b1 && sclk == 1'b0, "R1 pins", {cs_n, sclk}, 2);
    endtask

    task automatic t_valid_pair;
        logic [31:0] d;
        @(negedge clk); awv = 1; wa = 8'h68; wd = 32'hAB;
        @(negedge clk); awv = 0; wv = 1;
        @(negedge clk); wv = 0; wa = 8'h70; wd = 0; awv = 1;
        @(negedge clk); awv = 0;
        rd(8'h64, d); check(d == 32'h5, "R2 lone valid push", d, 5);
        check(cs_n == 1'b1, "R2 lone valid select", cs_n, 1);
    endtask

    task automatic t_slave_select;
        wr(8'h70, 32'h0); check(cs_n == 1'b0, "R3 select low", cs_n, 0);
        wr(8'h70, 32'h1); check(cs_n == 1'b1, "R3 select high", cs_n, 1);
    endtask

    task automatic t_inhibit;
        logic [31:0] d;
        int base = nsent;
        wr(8'h70, 0);
        wr(8'h68, 32'h9C); wr(8'h68, 32'h01); wr(8'h68, 32'h80);
        idle(60);
        check(nsent == base && sclk == 0, "R4 no clock while held", nsent - base, 0);
        rd(8'h64, d); check(d[0] == 1'b0, "R4 bytes kept", d, 4);
    endtask

    task automatic t_burst;
        logic [31:0] d;
        logic [7:0] exp_tx [3] = '{8'h9C, 8'h01, 8'h80};
        int base = nsent;
        wr(8'h60, 0);
        wait_sent(base + 3);
        check(nsent == base + 3, "R5 byte count", nsent - base, 3);
        for (int i = 0; i < 3; i++)
            check(sent[(base + i) % 64] == exp_tx[i], "R5 msb first", sent[(base + i) % 64], exp_tx[i]);
        check(bit_gap == DIV, "R7 bit period", bit_gap, DIV);
        check(hi_len == DIV / 2, "R7 high time", hi_len, DIV / 2);
        check(sclk == 1'b0, "R7 idle low", sclk, 0);
        for (int i = 0; i < 3; i++) begin
            rd(8'h6C, d);
            check(d[7:0] == reply_of(base + i), "R6 received order", d[7:0], reply_of(base + i));
        end
        rd(8'h64, d); check(d == 32'h5, "R6 queues drained", d, 5);
        wr(8'h60, 1);
    endtask

    task automatic t_cs_gate;
        logic [31:0] d;
        int base = nsent;
        wr(8'h70, 1); wr(8'h60, 0);
        wr(8'h68, 32'h47); wr(8'h68, 32'hB2);
        idle(60);
        check(nsent == base, "R11 no transfer deselected", nsent - base, 0);
        wr(8'h70, 0);
        wait_sent(base + 2);
        check(sent[base % 64] == 8'h47 && sent[(base + 1) % 64] == 8'hB2,
              "R11 released by select", sent[(base + 1) % 64], 8'hB2);
        for (int i = 0; i < 2; i++) begin
            rd(8'h6C, d);
            check(d[7:0] == reply_of(base + i), "R6 received after select", d[7:0], reply_of(base + i));
        end
        wr(8'h60, 1);
    endtask

    task automatic t_fifo_resets;
        logic [31:0] d;
        int base = nsent;
        wr(8'h68, 32'h5A); wr(8'h68, 32'hC3);
        wr(8'h60, 0); wait_sent(base + 2); wr(8'h60, 1);
        wr(8'h68, 32'h11);
        wr(8'h60, 32'h5);
        rd(8'h64, d); check(d[2] == 1 && d[0] == 0, "R8 receive reset only", d, 32'h4);
        wr(8'h60, 32'h3);
        rd(8'h64, d); check(d == 32'h5, "R8 transmit reset", d, 5);
    endtask

    task automatic t_tx_full;
        logic [31:0] d;
        int base = nsent;
        for (int i = 0; i < DEPTH; i++) wr(8'h68, 32'(8'(i * 17 + 3)));
        rd(8'h64, d); check(d[1] == 1'b1, "R9 full flag", d, 2);
        wr(8'h68, 32'hEE);
        wr(8'h60, 0);
        wait_sent(base + DEPTH);
        idle(100);
        check(nsent == base + DEPTH, "R9 extra write dropped", nsent - base, DEPTH);
        check(sent[(base + DEPTH - 1) % 64] == 8'((DEPTH - 1) * 17 + 3), "R9 last queued byte",
              sent[(base + DEPTH - 1) % 64], 8'((DEPTH - 1) * 17 + 3));
        wr(8'h60, 1);
        rd(8'h64, d); check(d[3] == 1 && d[4] == 0, "R10 receive full no overrun", d, 32'h9);
    endtask

    task automatic t_rx_overrun;
        logic [31:0] d;
        int first = nsent - DEPTH;
        wr(8'h68, 32'h77);
        wr(8'h60, 0); wait_sent(nsent + 1); wr(8'h60, 1);
        rd(8'h64, d); check(d[4] == 1 && d[3] == 1, "R10 overrun set", d, 32'h19);
        for (int i = 0; i < DEPTH; i++) begin
            rd(8'h6C, d);
            check(d[7:0] == reply_of(first + i), "R10 kept bytes", d[7:0], reply_of(first + i));
        end
        rd(8'h64, d); check(d[2] == 1 && d[4] == 1, "R10 dropped byte absent", d, 32'h15);
        wr(8'h60, 32'h5);
        rd(8'h64, d); check(d == 32'h5, "R8 receive reset clears overrun", d, 5);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        idle(4);
        rst_n = 1;
        idle(2);
        t_reset();
        t_valid_pair();
        t_slave_select();
        t_inhibit();
        t_burst();
        t_cs_gate();
        t_fifo_resets();
        t_tx_full();
        t_rx_overrun();
        finish_run();
    end

    initial begin
        repeat (150000) @(negedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end
endmodule